// File: doc/BRIEF.md
# NAND Read Timing Calculator

This block turns nanosecond timing targets for a NAND flash interface into the cycle counts and read-sampling settings that a flash controller runs with. A pulse on `start_i` captures the clock period, the number of chips sharing the bus, the setup, hold and address targets, a sample-delay target, and three signed device read parameters: access time, low-side output hold and high-side output hold. A negative device parameter means "not known". A single pulse on `done_o` marks the cycle in which every result is valid.

The computation runs as a sequence of steps. Each nanosecond target is raised for heavy bus loading and then converted to cycles by a serial ceiling divider. A delay shift and a delay limit are derived from the period. When all device parameters are known, the block sizes the read data eye. It places the ideal sample point at the centre of the eye and quantizes that point into a delay factor. It then trades extra data setup cycles against sample delay until the quantized point lies inside the eye. When a device parameter is not known, a simpler trade is made against the sample-delay target.

Top module: `nand_rd_timing_calc`

## Requirements
- R1: Setup cycles and hold cycles are max(ceil(target/P), 1). Address cycles are ceil(target/P) and may be 0. P is the captured period in ns and is at least 1.
- R2: All three targets are raised by 5 ns when the chip count is exactly 2 and by 10 ns when it is 3 or more. Counts of 0 and 1 leave the targets unchanged.
- R3: `half_per_o` is 1 exactly when P > 16. The delay shift is then 4, otherwise 3. The delay limit is 0 for P > 32, otherwise min((15*P) >> shift, 16).
- R4: If any device parameter is negative, the ideal delay starts at the sample-delay target. While it exceeds the delay limit and setup is below 255, one setup cycle is added and P is taken from the ideal delay, floored at 0.
- R5: With all device parameters known, eye = 5 + high-hold + P*setup - 9 - access. While eye <= 0 and setup < 255, setup gains one cycle and eye gains P.
- R6: Ideal delay = floor((9 + access + 5 + high-hold - P*setup)/2), floored at 0. While it exceeds the delay limit and setup < 255, setup gains one cycle, eye gains P and the ideal delay loses floor(P/2), floored at 0.
- R7: Delay factor = min(ceil((ideal << shift)/P), 15).
- R8: Let quantized = (factor*P) >> shift. While |quantized - ideal| > floor(eye/2) and setup < 255, one of two things happens. If quantized > ideal, the factor drops by one. Otherwise setup gains one cycle, eye gains P, the ideal delay loses floor(P/2)+P (floored at 0), and the factor is recomputed per R7.
- R9: The correction loops raise setup only one cycle at a time and never past 255. A setup count from R1 that is already above 255 is left unchanged.
- R10: `start_i` is taken only when the block is idle, and inputs are captured at that edge. `done_o` is high for exactly one cycle per accepted start. Results hold steady until the next accepted start. Reset clears all outputs and `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a calculation (taken when idle) |
| period_ns_i | input | PER_W | Controller clock period in ns, at least 1 |
| chips_i | input | CHIP_W | Number of chips on the bus |
| setup_ns_i | input | TIME_W | Data setup target, ns |
| hold_ns_i | input | TIME_W | Data hold target, ns |
| addr_ns_i | input | TIME_W | Address setup target, ns |
| sample_ns_i | input | TIME_W | Sample-delay target for the simple path, ns |
| acc_ns_i | input | TIME_W | Device read access time, signed, negative = unknown |
| lo_keep_ns_i | input | TIME_W | Device low-side output hold, signed, negative = unknown |
| hi_keep_ns_i | input | TIME_W | Device high-side output hold, signed, negative = unknown |
| done_o | output | 1 | One-cycle pulse, results valid |
| setup_cyc_o | output | CYC_W | Data setup cycles |
| hold_cyc_o | output | CYC_W | Data hold cycles |
| addr_cyc_o | output | CYC_W | Address setup cycles |
| half_per_o | output | 1 | Delay line driven by half periods |
| dly_fac_o | output | FAC_W | Read sample delay factor |

## Verification
Directed patterns separate the two paths. Zero targets expose the minimum-of-one rule. Chip counts of 1, 2 and 4 show each derating step. Periods of 16, 20 and 40 ns straddle the half-period and zero-limit thresholds. A large access time forces the eye-opening loop, a large high-side hold forces the delay-fit loop, and a 1 ns period with derated targets above 255 shows that the correction loops leave an oversized setup count untouched. Randomized vectors mix periods, chip counts and unknown parameters so that the window-correction loop both lowers the factor and adds setup, and a second start issued mid-calculation shows that inputs are captured only when idle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_DIVGO, S_DIVWAIT, S_PREP, S_SFIT, S_EYE, S_FIT, S_WIN, S_DONE
  } calc_st_e;

  typedef enum logic [1:0] {DV_DS, DV_DH, DV_AS, DV_SF} div_ph_e;
endpackage

// File: rtl/rtc_ceil_div.sv
// Restoring divider, one quotient bit per cycle.
module rtc_ceil_div #(
  parameter int DVD_W = 14,
  parameter int DVS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DVD_W-1:0] dvd_i,
  input  logic [DVS_W-1:0] dvs_i,
  output logic [DVD_W-1:0] quo_o,
  output logic             done_o
);
  localparam int CNT_W = $clog2(DVD_W + 1);

  logic [DVS_W-1:0] rem_q;
  logic [DVD_W-1:0] quo_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;
  logic [DVS_W:0]   shl;
  logic             ge;
  logic [DVS_W:0]   sub;

  always_comb begin
    shl = {rem_q, quo_q[DVD_W-1]};
    ge  = shl >= {1'b0, dvs_i};
    sub = shl - {1'b0, dvs_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        rem_q  <= '0;
        quo_q  <= dvd_i;
        cnt_q  <= CNT_W'(DVD_W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= ge ? sub[DVS_W-1:0] : shl[DVS_W-1:0];
        quo_q <= {quo_q[DVD_W-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign quo_o  = quo_q;
  assign done_o = done_q;
endmodule

// File: rtl/rtc_limits.sv
// Chip derating, half-period select and sample delay limit.
module rtc_limits #(
  parameter int PER_W       = 8,
  parameter int TIME_W      = 8,
  parameter int CHIP_W      = 3,
  parameter int FAC_W       = 4,
  parameter int DLL_MAX_PER = 32,
  parameter int DLL_MAX_DLY = 16
) (
  input  logic [PER_W-1:0]  per_i,
  input  logic [CHIP_W-1:0] chips_i,
  input  logic [TIME_W-1:0] tds_i,
  input  logic [TIME_W-1:0] tdh_i,
  input  logic [TIME_W-1:0] tas_i,
  output logic [TIME_W:0]   tds_o,
  output logic [TIME_W:0]   tdh_o,
  output logic [TIME_W:0]   tas_o,
  output logic              half_o,
  output logic [PER_W-1:0]  maxd_o
);
  localparam int PW      = FAC_W + PER_W;
  localparam int MAX_FAC = (1 << FAC_W) - 1;

  logic [TIME_W:0] add;
  logic [PW-1:0]   prod, shf;

  always_comb begin
    if (chips_i > CHIP_W'(2))       add = (TIME_W+1)'(10);
    else if (chips_i == CHIP_W'(2)) add = (TIME_W+1)'(5);
    else                            add = '0;
    tds_o  = (TIME_W+1)'(tds_i) + add;
    tdh_o  = (TIME_W+1)'(tdh_i) + add;
    tas_o  = (TIME_W+1)'(tas_i) + add;
    half_o = per_i > PER_W'(DLL_MAX_PER / 2);
    prod   = PW'(MAX_FAC) * PW'(per_i);
    shf    = half_o ? (prod >> 4) : (prod >> 3);
    if (per_i > PER_W'(DLL_MAX_PER))    maxd_o = '0;
    else if (shf > PW'(DLL_MAX_DLY))    maxd_o = PER_W'(DLL_MAX_DLY);
    else                                maxd_o = PER_W'(shf);
  end
endmodule

// File: rtl/rtc_window.sv
// Quantized sample point versus data eye.
module rtc_window #(
  parameter int PER_W = 8,
  parameter int FAC_W = 4,
  parameter int SW    = 20
) (
  input  logic [FAC_W-1:0]     fac_i,
  input  logic [PER_W-1:0]     per_i,
  input  logic                 half_i,
  input  logic signed [SW-1:0] ideal_i,
  input  logic signed [SW-1:0] eye_i,
  output logic                 late_o,
  output logic                 out_o
);
  localparam int PW = FAC_W + PER_W;

  logic [PW-1:0]        prod, qnt;
  logic signed [SW-1:0] qs, diff, err;

  always_comb begin
    prod   = PW'(fac_i) * PW'(per_i);
    qnt    = half_i ? (prod >> 4) : (prod >> 3);
    qs     = signed'(SW'(qnt));
    diff   = qs - ideal_i;
    err    = diff[SW-1] ? -diff : diff;
    out_o  = err > (eye_i >>> 1);
    late_o = qs > ideal_i;
  end
endmodule

// File: rtl/nand_rd_timing_calc.sv
module nand_rd_timing_calc
  import rtc_pkg::*;
#(
  parameter int PER_W       = 8,
  parameter int TIME_W      = 8,
  parameter int CHIP_W      = 3,
  parameter int FAC_W       = 4,
  parameter int CYC_W       = TIME_W + 1,
  parameter int MAX_SETUP   = 255,
  parameter int DLL_MAX_PER = 32,
  parameter int DLL_MAX_DLY = 16,
  parameter int MIN_PROP    = 5,
  parameter int MAX_PROP    = 9,
  parameter int RD_SETUP    = 0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [PER_W-1:0]         period_ns_i,
  input  logic [CHIP_W-1:0]        chips_i,
  input  logic [TIME_W-1:0]        setup_ns_i,
  input  logic [TIME_W-1:0]        hold_ns_i,
  input  logic [TIME_W-1:0]        addr_ns_i,
  input  logic [TIME_W-1:0]        sample_ns_i,
  input  logic signed [TIME_W-1:0] acc_ns_i,
  input  logic signed [TIME_W-1:0] lo_keep_ns_i,
  input  logic signed [TIME_W-1:0] hi_keep_ns_i,
  output logic                     done_o,
  output logic [CYC_W-1:0]         setup_cyc_o,
  output logic [CYC_W-1:0]         hold_cyc_o,
  output logic [CYC_W-1:0]         addr_cyc_o,
  output logic                     half_per_o,
  output logic [FAC_W-1:0]         dly_fac_o
);
  localparam int DVD_W   = TIME_W + 6;
  localparam int SW      = PER_W + CYC_W + 3;
  localparam int MAX_FAC = (1 << FAC_W) - 1;

  function automatic logic signed [SW-1:0] clamp0(input logic signed [SW-1:0] v);
    return v[SW-1] ? '0 : v;
  endfunction

  calc_st_e state_q;
  div_ph_e  phase_q;

  logic [PER_W-1:0]         per_q;
  logic [CHIP_W-1:0]        chips_q;
  logic [TIME_W-1:0]        tds_q, tdh_q, tas_q, sdly_q;
  logic signed [TIME_W-1:0] acc_q, hi_q;
  logic                     impr_q;
  logic [CYC_W-1:0]         ds_q, dh_q, as_q;
  logic [FAC_W-1:0]         fac_q;
  logic signed [SW-1:0]     ideal_q, eye_q, dsn_q;

  logic [TIME_W:0]      tds_d, tdh_d, tas_d;
  logic                 half;
  logic [PER_W-1:0]     maxd;
  logic                 late, outside;
  logic                 div_start, div_done;
  logic [DVD_W-1:0]     dvd, quo, sf_base;
  logic signed [SW-1:0] per_s, acc_s, hi_s, maxd_s, prod_s, eye_init;
  logic signed [SW-1:0] ideal_ctr, ideal_dec_p, ideal_dec_h, ideal_dec_w;
  logic                 ds_room, adj_st;

  rtc_limits #(
    .PER_W(PER_W), .TIME_W(TIME_W), .CHIP_W(CHIP_W), .FAC_W(FAC_W),
    .DLL_MAX_PER(DLL_MAX_PER), .DLL_MAX_DLY(DLL_MAX_DLY)
  ) u_lim (
    .per_i(per_q), .chips_i(chips_q), .tds_i(tds_q), .tdh_i(tdh_q), .tas_i(tas_q),
    .tds_o(tds_d), .tdh_o(tdh_d), .tas_o(tas_d), .half_o(half), .maxd_o(maxd)
  );

  rtc_window #(.PER_W(PER_W), .FAC_W(FAC_W), .SW(SW)) u_win (
    .fac_i(fac_q), .per_i(per_q), .half_i(half), .ideal_i(ideal_q), .eye_i(eye_q),
    .late_o(late), .out_o(outside)
  );

  rtc_ceil_div #(.DVD_W(DVD_W), .DVS_W(PER_W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(div_start), .dvd_i(dvd), .dvs_i(per_q),
    .quo_o(quo), .done_o(div_done)
  );

  always_comb begin
    per_s       = signed'(SW'(per_q));
    acc_s       = SW'(acc_q);
    hi_s        = SW'(hi_q);
    maxd_s      = signed'(SW'(maxd));
    prod_s      = signed'(SW'(per_q) * SW'(ds_q));
    eye_init    = SW'(MIN_PROP) + hi_s + prod_s - SW'(MAX_PROP + RD_SETUP) - acc_s;
    ideal_ctr   = (SW'(MAX_PROP + RD_SETUP + MIN_PROP) + acc_s + hi_s - dsn_q) >>> 1;
    ideal_dec_p = ideal_q - per_s;
    ideal_dec_h = ideal_q - (per_s >>> 1);
    ideal_dec_w = ideal_q - (per_s >>> 1) - per_s;
    ds_room     = ds_q < CYC_W'(MAX_SETUP);
    sf_base     = half ? (ideal_q[DVD_W-1:0] << 4) : (ideal_q[DVD_W-1:0] << 3);
    unique case (phase_q)
      DV_DS:   dvd = DVD_W'(tds_d) + DVD_W'(per_q) - 1'b1;
      DV_DH:   dvd = DVD_W'(tdh_d) + DVD_W'(per_q) - 1'b1;
      DV_AS:   dvd = DVD_W'(tas_d) + DVD_W'(per_q) - 1'b1;
      default: dvd = sf_base + DVD_W'(per_q) - 1'b1;
    endcase
    div_start = state_q == S_DIVGO;
    adj_st    = state_q inside {S_SFIT, S_EYE, S_FIT, S_WIN};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      phase_q <= DV_DS;
      per_q   <= '0;
      chips_q <= '0;
      tds_q   <= '0;
      tdh_q   <= '0;
      tas_q   <= '0;
      sdly_q  <= '0;
      acc_q   <= '0;
      hi_q    <= '0;
      impr_q  <= 1'b0;
      ds_q    <= '0;
      dh_q    <= '0;
      as_q    <= '0;
      fac_q   <= '0;
      ideal_q <= '0;
      eye_q   <= '0;
      dsn_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          per_q   <= period_ns_i;
          chips_q <= chips_i;
          tds_q   <= setup_ns_i;
          tdh_q   <= hold_ns_i;
          tas_q   <= addr_ns_i;
          sdly_q  <= sample_ns_i;
          acc_q   <= acc_ns_i;
          hi_q    <= hi_keep_ns_i;
          impr_q  <= (acc_ns_i >= 0) && (lo_keep_ns_i >= 0) && (hi_keep_ns_i >= 0);
          phase_q <= DV_DS;
          state_q <= S_DIVGO;
        end
        S_DIVGO: state_q <= S_DIVWAIT;
        S_DIVWAIT: if (div_done) begin
          unique case (phase_q)
            DV_DS: begin
              ds_q    <= (quo == '0) ? CYC_W'(1) : CYC_W'(quo);
              phase_q <= DV_DH;
              state_q <= S_DIVGO;
            end
            DV_DH: begin
              dh_q    <= (quo == '0) ? CYC_W'(1) : CYC_W'(quo);
              phase_q <= DV_AS;
              state_q <= S_DIVGO;
            end
            DV_AS: begin
              as_q    <= CYC_W'(quo);
              state_q <= S_PREP;
            end
            default: begin
              fac_q   <= (quo > DVD_W'(MAX_FAC)) ? FAC_W'(MAX_FAC) : FAC_W'(quo);
              state_q <= impr_q ? S_WIN : S_DONE;
            end
          endcase
        end
        S_PREP: begin
          if (impr_q) begin
            dsn_q   <= prod_s;
            eye_q   <= eye_init;
            state_q <= S_EYE;
          end else begin
            ideal_q <= SW'(sdly_q) + SW'(RD_SETUP);
            state_q <= S_SFIT;
          end
        end
        S_SFIT: begin
          if (ideal_q > maxd_s && ds_room) begin
            ds_q    <= ds_q + 1'b1;
            ideal_q <= clamp0(ideal_dec_p);
          end else begin
            phase_q <= DV_SF;
            state_q <= S_DIVGO;
          end
        end
        S_EYE: begin
          if ((eye_q[SW-1] || eye_q == '0) && ds_room) begin
            ds_q  <= ds_q + 1'b1;
            dsn_q <= dsn_q + per_s;
            eye_q <= eye_q + per_s;
          end else begin
            ideal_q <= clamp0(ideal_ctr);
            state_q <= S_FIT;
          end
        end
        S_FIT: begin
          if (ideal_q > maxd_s && ds_room) begin
            ds_q    <= ds_q + 1'b1;
            dsn_q   <= dsn_q + per_s;
            eye_q   <= eye_q + per_s;
            ideal_q <= clamp0(ideal_dec_h);
          end else begin
            phase_q <= DV_SF;
            state_q <= S_DIVGO;
          end
        end
        S_WIN: begin
          if (outside && ds_room) begin
            if (late) begin
              if (fac_q != '0) fac_q <= fac_q - 1'b1;
            end else begin
              ds_q    <= ds_q + 1'b1;
              dsn_q   <= dsn_q + per_s;
              eye_q   <= eye_q + per_s;
              ideal_q <= clamp0(ideal_dec_w);
              phase_q <= DV_SF;
              state_q <= S_DIVGO;
            end
          end else begin
            state_q <= S_DONE;
          end
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign done_o      = state_q == S_DONE;
  assign setup_cyc_o = ds_q;
  assign hold_cyc_o  = dh_q;
  assign addr_cyc_o  = as_q;
  assign half_per_o  = half;
  assign dly_fac_o   = fac_q;
endmodule

// File: rtl/nand_rd_timing_calc_chk.sv
module nand_rd_timing_calc_chk #(
  parameter int CYC_W     = 9,
  parameter int FAC_W     = 4,
  parameter int SW        = 20,
  parameter int MAX_SETUP = 255
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 start_i,
  input logic                 done_o,
  input logic [CYC_W-1:0]     setup_cyc_o,
  input logic [CYC_W-1:0]     hold_cyc_o,
  input logic [CYC_W-1:0]     addr_cyc_o,
  input logic                 half_per_o,
  input logic [FAC_W-1:0]     dly_fac_o,
  input logic                 adj_st,
  input logic signed [SW-1:0] ideal_q
);
  logic busy_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                busy_c <= 1'b0;
    else if (done_o)            busy_c <= 1'b0;
    else if (start_i && !busy_c) busy_c <= 1'b1;
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_c && !start_i) |=> ($stable(setup_cyc_o) && $stable(hold_cyc_o) &&
      $stable(addr_cyc_o) && $stable(half_per_o) && $stable(dly_fac_o))); // R10

  AST_SETUP_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> setup_cyc_o != '0); // R1

  AST_HOLD_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> hold_cyc_o != '0); // R1

  AST_SETUP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adj_st |=> (setup_cyc_o == $past(setup_cyc_o) ||
      (setup_cyc_o == $past(setup_cyc_o) + CYC_W'(1) &&
       $past(setup_cyc_o) < CYC_W'(MAX_SETUP)))); // R9

  AST_IDEAL_NONNEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ideal_q[SW-1]); // R6
endmodule

bind nand_rd_timing_calc nand_rd_timing_calc_chk #(
  .CYC_W(CYC_W), .FAC_W(FAC_W), .SW(SW), .MAX_SETUP(MAX_SETUP)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .done_o(done_o),
  .setup_cyc_o(setup_cyc_o), .hold_cyc_o(hold_cyc_o), .addr_cyc_o(addr_cyc_o),
  .half_per_o(half_per_o), .dly_fac_o(dly_fac_o), .adj_st(adj_st), .ideal_q(ideal_q)
);

// File: tb/nand_rd_timing_calc_tb_top.sv
module nand_rd_timing_calc_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] per = '0;
  logic [2:0] chips = '0;
  logic [7:0] tds = '0, tdh = '0, tas = '0, sdly = '0;
  logic signed [7:0] acc = '0, lo = '0, hi = '0;
  logic done;
  logic [8:0] ds_o, dh_o, as_o;
  logic hp_o;
  logic [3:0] fac_o;

  always #10 clk = ~clk;

  nand_rd_timing_calc dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .period_ns_i(per), .chips_i(chips),
    .setup_ns_i(tds), .hold_ns_i(tdh), .addr_ns_i(tas), .sample_ns_i(sdly),
    .acc_ns_i(acc), .lo_keep_ns_i(lo), .hi_keep_ns_i(hi), .done_o(done),
    .setup_cyc_o(ds_o), .hold_cyc_o(dh_o), .addr_cyc_o(as_o), .half_per_o(hp_o),
    .dly_fac_o(fac_o)
  );

  typedef struct {
    int    ds, dh, as, hp, fac;
    string tag;
  } exp_t;

  exp_t sb_q[$];
  int checks = 0, errors = 0, pushed = 0, popped = 0;
  bit done_prev = 1'b0;
  bit finished = 1'b0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int cdiv(int t, int p);
    return (t + p - 1) / p;
  endfunction

  function automatic exp_t model(int p, int n, int a_ds, int a_dh, int a_as, int sd,
                                 int ac, int lk, int hk);
    exp_t e;
    int add, sh, maxd, ideal, dsn, eye, q, err, f, ds;
    add = (n > 2) ? 10 : ((n == 2) ? 5 : 0);           // R2
    ds = cdiv(a_ds + add, p); if (ds < 1) ds = 1;       // R1
    e.dh = cdiv(a_dh + add, p); if (e.dh < 1) e.dh = 1;
    e.as = cdiv(a_as + add, p);
    e.hp = (p > 16) ? 1 : 0;                            // R3
    sh = e.hp ? 4 : 3;
    maxd = (p > 32) ? 0 : (((15 * p) >> sh) > 16 ? 16 : ((15 * p) >> sh));
    if (ac < 0 || lk < 0 || hk < 0) begin               // R4
      ideal = sd;
      while (ideal > maxd && ds < 255) begin
        ds++; ideal -= p; if (ideal < 0) ideal = 0;
      end
      f = cdiv(ideal << sh, p); if (f > 15) f = 15;
    end else begin
      dsn = p * ds;
      eye = 5 + hk + dsn - 9 - ac;                      // R5
      while (eye <= 0 && ds < 255) begin
        ds++; dsn += p; eye += p;
      end
      ideal = (9 + ac + 5 + hk - dsn) >>> 1;            // R6
      if (ideal < 0) ideal = 0;
      while (ideal > maxd && ds < 255) begin
        ds++; dsn += p; eye += p; ideal -= (p >> 1); if (ideal < 0) ideal = 0;
      end
      f = cdiv(ideal << sh, p); if (f > 15) f = 15;     // R7
      forever begin                                     // R8
        q = (f * p) >> sh;
        err = (q > ideal) ? q - ideal : ideal - q;
        if (!(err > (eye >>> 1) && ds < 255)) break;
        if (q > ideal) begin
          if (f != 0) f--;
        end else begin
          ds++; dsn += p; eye += p; ideal -= (p >> 1) + p;
          if (ideal < 0) ideal = 0;
          f = cdiv(ideal << sh, p); if (f > 15) f = 15;
        end
      end
    end
    e.ds = ds;
    e.fac = f;
    return e;
  endfunction

  task automatic drive(int p, int n, int a_ds, int a_dh, int a_as, int sd,
                       int ac, int lk, int hk);
    per = 8'(p); chips = 3'(n); tds = 8'(a_ds); tdh = 8'(a_dh); tas = 8'(a_as);
    sdly = 8'(sd); acc = 8'(ac); lo = 8'(lk); hi = 8'(hk);
  endtask

  task automatic run_vec(string tag, int p, int n, int a_ds, int a_dh, int a_as,
                         int sd, int ac, int lk, int hk, bit poke);
    exp_t e;
    int s_ds, s_dh, s_as, s_hp, s_f;
    e = model(p, n, a_ds, a_dh, a_as, sd, ac, lk, hk);
    e.tag = tag;
    sb_q.push_back(e);
    pushed++;
    @(negedge clk);
    drive(p, n, a_ds, a_dh, a_as, sd, ac, lk, hk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R10: a start while busy and changed inputs must not matter
      repeat (3) @(negedge clk);
      drive(3, 5, 200, 150, 90, 77, -3, 4, 9);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      drive(90, 1, 1, 1, 1, 1, 1, 1, 1);
    end
    wait (popped == pushed);
    s_ds = int'(ds_o); s_dh = int'(dh_o); s_as = int'(as_o);
    s_hp = int'(hp_o); s_f = int'(fac_o);
    drive(2, 7, 250, 250, 250, 250, 100, 100, 100);
    repeat (4) @(negedge clk);
    chk("R10", "held setup", int'(ds_o), s_ds);
    chk("R10", "held factor", int'(fac_o), s_f);
    chk("R10", "held hold/addr/half", int'(dh_o) + 1000 * int'(as_o) + 100000 * int'(hp_o),
        s_dh + 1000 * s_as + 100000 * s_hp);
  endtask

  // Monitor: pop expected item on each done pulse
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        if (done_prev) chk("R10", "done width", 2, 1);
        if (sb_q.size() == 0) begin
          chk("R10", "unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(e.tag, "setup_cyc", int'(ds_o), e.ds);
          chk(e.tag, "hold_cyc", int'(dh_o), e.dh);
          chk(e.tag, "addr_cyc", int'(as_o), e.as);
          chk(e.tag, "half_per", int'(hp_o), e.hp);
          chk(e.tag, "dly_fac", int'(fac_o), e.fac);
          popped++;
        end
      end
      done_prev = done;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", "reset done", int'(done), 0);
    chk("R10", "reset outputs", int'(ds_o) + int'(dh_o) + int'(as_o) + int'(fac_o) + int'(hp_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_vec("R1", 10, 1, 0, 0, 0, 0, 20, 5, 5, 1'b0);
    run_vec("R1", 7, 0, 15, 22, 8, 0, 12, 3, 6, 1'b0);
    run_vec("R2", 10, 2, 10, 10, 10, 0, 20, 5, 5, 1'b0);
    run_vec("R2", 10, 4, 10, 10, 10, 0, 20, 5, 5, 1'b0);
    run_vec("R3", 16, 1, 20, 10, 5, 0, 18, 4, 6, 1'b0);
    run_vec("R3", 20, 1, 20, 10, 5, 0, 18, 4, 6, 1'b0);
    run_vec("R3", 40, 1, 20, 10, 5, 0, 18, 4, 6, 1'b0);
    run_vec("R4", 10, 1, 12, 8, 4, 30, -1, 5, 5, 1'b0);
    run_vec("R4", 5, 3, 0, 0, 0, 200, 10, -5, 5, 1'b0);
    run_vec("R4", 25, 1, 30, 10, 0, 9, 10, 5, -2, 1'b0);
    run_vec("R5", 10, 1, 5, 5, 5, 0, 100, 2, 0, 1'b0);
    run_vec("R6", 10, 1, 5, 5, 5, 0, 0, 2, 100, 1'b0);
    run_vec("R7", 25, 1, 40, 10, 10, 0, 20, 3, 10, 1'b0);
    run_vec("R8", 12, 2, 20, 10, 10, 0, 30, 4, 3, 1'b0);
    run_vec("R8", 30, 1, 10, 10, 10, 0, 16, 3, 12, 1'b0);
    run_vec("R9", 1, 4, 255, 255, 255, 0, 0, 0, 0, 1'b0);
    run_vec("R9", 1, 1, 0, 0, 0, 0, 127, 0, 0, 1'b0);
    run_vec("R10", 10, 1, 25, 12, 6, 0, 20, 5, 5, 1'b1);

    for (int k = 0; k < 40; k++) begin
      int p, n, ac, lk, hk;
      p  = int'($urandom_range(4, 60));
      n  = int'($urandom_range(0, 5));
      ac = int'($urandom_range(0, 60));
      lk = int'($urandom_range(0, 10));
      hk = int'($urandom_range(0, 40));
      if (k % 4 == 0) lk = -1;
      run_vec("R8", p, n, int'($urandom_range(0, 60)), int'($urandom_range(0, 40)),
              int'($urandom_range(0, 30)), int'($urandom_range(0, 80)), ac, lk, hk, 1'b0);
    end

    repeat (5) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule